// File: doc/BRIEF.md
# Debug Halt and Step Controller

This block sits between an external debugger's 32-bit register bus and a processor core. Through it the debugger can stop the core, let it execute exactly one instruction at a time, move values between the debugger and the core's register file, and then let the core run freely again. It drives a halt request toward the core. It takes back an instruction-retired pulse and a stopped indication from the core, and it reports the halted condition to the debugger as a status bit.

There are four word registers at byte offsets 0x0, 0x4, 0x8 and 0xC:
- a keyed control/status word (`CTL`);
- a write-only core-register selector (`SEL`) that launches a transfer;
- a transfer data word (`DAT`);
- an exception/monitor control word (`EMC`) whose value is offered to the rest of the chip.

Register fields fall into two reset domains. The asynchronous power-on reset clears everything. A warm clear is caused by either system reset or a vector-reset request, and it acts on only a few bits.

Top module: `dbg_halt_step`

## Requirements
- R1: The register word is chosen by `bus_addr[3:2]` (0 = CTL, 1 = SEL, 2 = DAT, 3 = EMC), and accesses with `bus_addr[1:0]` non-zero are ignored. A read of SEL returns 0. A CTL read returns the debug-enable bit at bit 0, halt at bit 1, step at bit 2, interrupt-mask at bit 3, transfer-ready at bit 16 and halted status at bit 17, with all other bits 0.
- R2: A CTL write loads bits 3:0 only when `bus_wdata[31:16]` equals 0xA05F. Any other CTL write leaves the register unchanged. The interrupt-mask bit drives `core_irq_mask`.
- R3: `core_halt_req` is asserted only while debug-enable is 1. With enable 0, setting the halt or step bit leaves the core running.
- R4: The halted status bit (CTL bit 17) is set one cycle after the core reports stopped under a halt request. It clears in the cycle the core resumes after the request is withdrawn.
- R5: While halted with step = 1, a keyed CTL write that clears halt lets exactly one instruction retire. The core is then halted again and bit 17 sets again. Each further keyed write with step = 1 and halt = 0 gives one more instruction.
- R6: A keyed CTL write that clears debug-enable releases the core, and it retires instructions continuously.
- R7: A SEL write starts a transfer of the register numbered by `bus_wdata[4:0]`. `bus_wdata[16]` sets the direction: 1 sends DAT to the core, 0 loads DAT from the core. CTL bit 16 reads 0 from the SEL write until the core acknowledges, then reads 1.
- R8: Power-on reset clears CTL bits 3:0, halted status, DAT and EMC, and sets the ready bit. After it, CTL reads 0x00010000 and EMC reads 0.
- R9: A warm clear (system reset low or vector-reset high at a clock edge) clears only the halt bit and EMC bits 19:16. Enable, step, mask and the other EMC bits keep their values.
- R10: EMC keeps only the writable bits 0x010F07F1 of a written word. A write of all ones reads back as 0x010F07F1.
- R11: No instruction retires while the core is halted by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, sampled, active low (warm clear) |
| vect_rst | input | 1 | Vector-reset request, sampled (warm clear) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_halt_req | output | 1 | Halt request to the core |
| core_irq_mask | output | 1 | Interrupt mask request to the core |
| core_retired | input | 1 | One-cycle pulse per retired instruction |
| core_stopped | input | 1 | Core is not executing |
| xfer_req | output | 1 | Core-register transfer pending |
| xfer_dir | output | 1 | 1 = write to core register, 0 = read |
| xfer_reg | output | 5 | Core register number |
| xfer_wdata | output | 32 | Value sent to the core register |
| xfer_ack | input | 1 | Core completes the transfer |
| xfer_rdata | input | 32 | Core register value on a read |
| exc_ctrl | output | 32 | Current exception/monitor control word |

## Verification
The hardest situation to reach is the single step. The halt request has to drop for exactly one retirement and come back before the core can start a second instruction. This can only be seen with a core that reacts to the request cycle by cycle. The bench therefore contains a behavioural core that retires one instruction in every cycle it is not held. It counts retirements across repeated step commands and across long halted intervals. Warm clears are applied while the core is halted and EMC is all ones, so that both domains can be seen in the state that follows.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BUS_ADDR_W = 4;
  localparam int unsigned REGSEL_W   = 5;

  localparam logic [1:0] OFS_CTL = 2'd0;
  localparam logic [1:0] OFS_SEL = 2'd1;
  localparam logic [1:0] OFS_DAT = 2'd2;
  localparam logic [1:0] OFS_EMC = 2'd3;

  localparam logic [15:0] CTL_KEY = 16'hA05F;
  localparam int unsigned SEL_DIR_BIT = 16;

  localparam logic [WORD_W-1:0] EMC_WMASK = 32'h010F_07F1;
  localparam logic [WORD_W-1:0] EMC_WARM  = 32'h000F_0000;

  function automatic logic key_ok(input logic [15:0] upper);
    return upper == CTL_KEY;
  endfunction

  // halt is requested for a held halt, a finished step, or the retirement of a stepped instruction
  function automatic logic halt_request(input logic en, input logic halt,
                                        input logic stepped, input logic step,
                                        input logic retired);
    return en & (halt | stepped | (step & retired));
  endfunction

  function automatic logic [WORD_W-1:0] emc_store(input logic [WORD_W-1:0] w);
    return w & EMC_WMASK;
  endfunction

  function automatic logic [WORD_W-1:0] emc_warm(input logic [WORD_W-1:0] v);
    return v & ~EMC_WARM;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_word(input logic en, input logic halt,
                                                 input logic step, input logic mask,
                                                 input logic ready, input logic shalt);
    logic [WORD_W-1:0] w;
    w     = '0;
    w[0]  = en;
    w[1]  = halt;
    w[2]  = step;
    w[3]  = mask;
    w[16] = ready;
    w[17] = shalt;
    return w;
  endfunction
endpackage

// File: rtl/dbg_hs_ctl.sv
module dbg_hs_ctl
  import dbg_hs_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        warm_clr,
  input  logic        ctl_wr,
  input  logic [15:0] wkey,
  input  logic [3:0]  wbits,
  input  logic        core_retired,
  input  logic        core_stopped,
  output logic        en_q,
  output logic        halt_q,
  output logic        step_q,
  output logic        mask_q,
  output logic        step_latch_q,
  output logic        s_halt_q,
  output logic        halt_req
);
  logic keyed_wr;
  logic step_done;

  assign keyed_wr  = ctl_wr & key_ok(wkey);
  assign step_done = en_q & step_q & ~halt_q & core_retired;
  assign halt_req  = halt_request(en_q, halt_q, step_latch_q, step_q, core_retired);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q         <= 1'b0;
      halt_q       <= 1'b0;
      step_q       <= 1'b0;
      mask_q       <= 1'b0;
      step_latch_q <= 1'b0;
      s_halt_q     <= 1'b0;
    end else begin
      if (keyed_wr) begin
        en_q   <= wbits[0];
        halt_q <= wbits[1];
        step_q <= wbits[2];
        mask_q <= wbits[3];
      end
      if (warm_clr) halt_q <= 1'b0;
      if (warm_clr || keyed_wr) step_latch_q <= 1'b0;
      else if (step_done)       step_latch_q <= 1'b1;
      s_halt_q <= halt_req & core_stopped;
    end
  end
endmodule

// File: rtl/dbg_hs_xfer.sv
module dbg_hs_xfer
  import dbg_hs_pkg::*;
#(
  parameter int unsigned SEL_W = REGSEL_W
)(
  input  logic              clk,
  input  logic              por_n,
  input  logic              sel_wr,
  input  logic              dat_wr,
  input  logic [SEL_W-1:0]  wsel,
  input  logic              wdir,
  input  logic [WORD_W-1:0] wdata,
  input  logic              xfer_ack,
  input  logic [WORD_W-1:0] xfer_rdata,
  output logic              xfer_req,
  output logic              xfer_dir,
  output logic [SEL_W-1:0]  xfer_reg,
  output logic [WORD_W-1:0] data_q,
  output logic              ready_q
);
  logic done;
  assign done = xfer_req & xfer_ack;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      xfer_req <= 1'b0;
      xfer_dir <= 1'b0;
      xfer_reg <= '0;
      data_q   <= '0;
      ready_q  <= 1'b1;
    end else begin
      if (sel_wr) begin
        xfer_req <= 1'b1;
        xfer_dir <= wdir;
        xfer_reg <= wsel;
        ready_q  <= 1'b0;
      end else if (done) begin
        xfer_req <= 1'b0;
        ready_q  <= 1'b1;
        if (!xfer_dir) data_q <= xfer_rdata;
      end
      if (dat_wr) data_q <= wdata;
    end
  end
endmodule

// File: rtl/dbg_hs_emc.sv
module dbg_hs_emc
  import dbg_hs_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_clr,
  input  logic              emc_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] emc_q
);
  logic [WORD_W-1:0] written;
  assign written = emc_wr ? emc_store(wdata) : emc_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        emc_q <= '0;
    else if (warm_clr) emc_q <= emc_warm(written);
    else               emc_q <= written;
  end
endmodule

// File: rtl/dbg_halt_step.sv
module dbg_halt_step
  import dbg_hs_pkg::*;
#(
  parameter int unsigned SEL_W = REGSEL_W
)(
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  sys_rst_n,
  input  logic                  vect_rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic                  core_halt_req,
  output logic                  core_irq_mask,
  input  logic                  core_retired,
  input  logic                  core_stopped,
  output logic                  xfer_req,
  output logic                  xfer_dir,
  output logic [SEL_W-1:0]      xfer_reg,
  output logic [WORD_W-1:0]     xfer_wdata,
  input  logic                  xfer_ack,
  input  logic [WORD_W-1:0]     xfer_rdata,
  output logic [WORD_W-1:0]     exc_ctrl
);
  logic       hit;
  logic [1:0] word_ix;
  logic       ctl_wr, sel_wr, dat_wr, emc_wr;
  logic       warm_clr;
  logic       en_q, halt_q, step_q, mask_q, step_latch_q, s_halt_q, ready_q;
  logic [WORD_W-1:0] data_q;

  assign word_ix  = bus_addr[3:2];
  assign hit      = bus_sel & (bus_addr[1:0] == 2'b00);
  assign ctl_wr   = hit & bus_wr & (word_ix == OFS_CTL);
  assign sel_wr   = hit & bus_wr & (word_ix == OFS_SEL);
  assign dat_wr   = hit & bus_wr & (word_ix == OFS_DAT);
  assign emc_wr   = hit & bus_wr & (word_ix == OFS_EMC);
  assign warm_clr = ~sys_rst_n | vect_rst;

  dbg_hs_ctl ctl_i (
    .clk(clk), .por_n(por_n), .warm_clr(warm_clr), .ctl_wr(ctl_wr),
    .wkey(bus_wdata[31:16]), .wbits(bus_wdata[3:0]),
    .core_retired(core_retired), .core_stopped(core_stopped),
    .en_q(en_q), .halt_q(halt_q), .step_q(step_q), .mask_q(mask_q),
    .step_latch_q(step_latch_q), .s_halt_q(s_halt_q), .halt_req(core_halt_req)
  );

  dbg_hs_xfer #(.SEL_W(SEL_W)) xfer_i (
    .clk(clk), .por_n(por_n), .sel_wr(sel_wr), .dat_wr(dat_wr),
    .wsel(bus_wdata[SEL_W-1:0]), .wdir(bus_wdata[SEL_DIR_BIT]), .wdata(bus_wdata),
    .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_reg(xfer_reg),
    .data_q(data_q), .ready_q(ready_q)
  );

  dbg_hs_emc emc_i (
    .clk(clk), .por_n(por_n), .warm_clr(warm_clr), .emc_wr(emc_wr),
    .wdata(bus_wdata), .emc_q(exc_ctrl)
  );

  assign core_irq_mask = en_q & mask_q;
  assign xfer_wdata    = data_q;

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      unique case (word_ix)
        OFS_CTL: bus_rdata = ctl_word(en_q, halt_q, step_q, mask_q, ready_q, s_halt_q);
        OFS_SEL: bus_rdata = '0;
        OFS_DAT: bus_rdata = data_q;
        OFS_EMC: bus_rdata = exc_ctrl;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_halt_step_chk.sv
module dbg_halt_step_chk
  import dbg_hs_pkg::*;
(
  input logic        clk,
  input logic        por_n,
  input logic        warm_clr,
  input logic        ctl_wr,
  input logic [15:0] wkey,
  input logic        en_q,
  input logic        halt_q,
  input logic        step_q,
  input logic        mask_q,
  input logic        step_latch_q,
  input logic        s_halt_q,
  input logic        ready_q,
  input logic        core_halt_req,
  input logic        core_stopped,
  input logic        core_retired,
  input logic        xfer_req,
  input logic        xfer_ack,
  input logic [31:0] exc_ctrl
);
  // R3
  halt_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_halt_req |-> en_q);

  // R4
  halted_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(s_halt_q) |-> $past(core_stopped && core_halt_req));

  // R4
  halted_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !core_halt_req |=> !s_halt_q);

  // R5
  step_rehalt_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(step_latch_q) |-> $past(core_retired && step_q));

  // R7
  ready_on_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready_q) |-> $past(xfer_req && xfer_ack));

  // R9
  warm_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm_clr |=> (!halt_q && exc_ctrl[19:16] == 4'h0));

  // R2
  unkeyed_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_wr && wkey != CTL_KEY) |=> $stable({en_q, step_q, mask_q}));
endmodule

bind dbg_halt_step dbg_halt_step_chk chk_i (
  .clk(clk), .por_n(por_n), .warm_clr(warm_clr), .ctl_wr(ctl_wr),
  .wkey(bus_wdata[31:16]), .en_q(en_q), .halt_q(halt_q), .step_q(step_q),
  .mask_q(mask_q), .step_latch_q(step_latch_q), .s_halt_q(s_halt_q),
  .ready_q(ready_q), .core_halt_req(core_halt_req), .core_stopped(core_stopped),
  .core_retired(core_retired), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .exc_ctrl(exc_ctrl)
);

// File: tb/dbg_halt_step_tb_top.sv
module dbg_halt_step_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic        vect_rst = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_halt_req, core_irq_mask;
  logic        core_retired, core_stopped;
  logic        xfer_req, xfer_dir;
  logic [4:0]  xfer_reg;
  logic [31:0] xfer_wdata;
  logic        xfer_ack = 1'b0;
  logic [31:0] xfer_rdata = '0;
  logic [31:0] exc_ctrl;

  int checks = 0, failures = 0;
  int rcount = 0;
  int rsp_cnt = 0;
  logic [4:0]  last_wr_reg = '0;
  logic [31:0] last_wr_val = '0;
  bit   done = 0;
  logic mon_go = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];

  always #4 clk = ~clk;

  dbg_halt_step dut_i (.*);

  // behavioural core: one retirement per free-running cycle
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      core_stopped <= 1'b0;
      core_retired <= 1'b0;
    end else if (core_halt_req) begin
      core_stopped <= 1'b1;
      core_retired <= 1'b0;
    end else begin
      core_stopped <= 1'b0;
      core_retired <= 1'b1;
    end
  end

  always @(posedge clk) if (core_retired) rcount <= rcount + 1;

  // register-file responder: acknowledge three cycles into a transfer
  always @(posedge clk) begin
    xfer_ack <= 1'b0;
    if (xfer_req && !xfer_ack) begin
      if (rsp_cnt == 2) begin
        rsp_cnt    <= 0;
        xfer_ack   <= 1'b1;
        xfer_rdata <= 32'hC0DE_0000 | {27'd0, xfer_reg};
        if (xfer_dir) begin
          last_wr_reg <= xfer_reg;
          last_wr_val <= xfer_wdata;
        end
      end else rsp_cnt <= rsp_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_go && rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.tag = tag;
    rd_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; mon_go = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; mon_go = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int c0;
    idle(3); #1 por_n = 1'b1;
    // R8 reset state
    bus_read(4'h0, 32'h0001_0000, "R8 ctl after power-on");
    bus_read(4'hC, 32'h0, "R8 emc after power-on");
    bus_read(4'h4, 32'h0, "R1 selector reads zero");

    // R3 halt without enable keeps the core running
    bus_write(4'h0, 32'hA05F_0002);
    @(negedge clk); c0 = rcount; idle(10); @(negedge clk);
    check("R3 retires with enable low", 32'(rcount > c0 + 5), 32'd1);
    check("R3 no halt request", {31'd0, core_halt_req}, 32'd0);
    bus_read(4'h0, 32'h0001_0002, "R1 ctl fields");

    // R4 halt and acknowledge
    bus_write(4'h0, 32'hA05F_0003);
    idle(5);
    bus_read(4'h0, 32'h0003_0003, "R4 halted status set");
    @(negedge clk); c0 = rcount; idle(20); @(negedge clk);
    check("R11 no retire while halted", rcount, c0);

    // R2 unkeyed write ignored
    bus_write(4'h0, 32'h0000_0000);
    idle(3);
    bus_read(4'h0, 32'h0003_0003, "R2 unkeyed write ignored");
    check("R2 still halted", {31'd0, core_halt_req}, 32'd1);

    // R5 single steps
    bus_write(4'h0, 32'hA05F_0007);
    @(negedge clk); c0 = rcount;
    bus_write(4'h0, 32'hA05F_0005);
    idle(10); @(negedge clk);
    check("R5 one retire per step", rcount - c0, 32'd1);
    bus_read(4'h0, 32'h0003_0005, "R5 halted after step");
    @(negedge clk); c0 = rcount;
    bus_write(4'h0, 32'hA05F_0005);
    idle(10); @(negedge clk);
    check("R5 second step", rcount - c0, 32'd1);
    bus_read(4'h0, 32'h0003_0005, "R4 halted again");

    // R7 transfers
    bus_write(4'h4, 32'h0000_0005);
    bus_read(4'h0, 32'h0002_0005, "R7 ready low during transfer");
    idle(8);
    bus_read(4'h0, 32'h0003_0005, "R7 ready high after ack");
    bus_read(4'h8, 32'hC0DE_0005, "R7 data from core");
    bus_write(4'h8, 32'h1234_5678);
    bus_write(4'h4, 32'h0001_0003);
    idle(8);
    check("R7 write reg number", {27'd0, last_wr_reg}, 32'd3);
    check("R7 write value", last_wr_val, 32'h1234_5678);

    // R10 emc write mask
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'hC, 32'h010F_07F1, "R10 emc writable bits");
    check("R10 emc output", exc_ctrl, 32'h010F_07F1);

    // R9 system reset as warm clear
    bus_write(4'h0, 32'hA05F_0003);
    idle(3);
    @(posedge clk); #1 sys_rst_n = 1'b0;
    @(posedge clk); #1 sys_rst_n = 1'b1;
    idle(5);
    bus_read(4'h0, 32'h0001_0001, "R9 sys reset clears halt only");
    bus_read(4'hC, 32'h0100_07F1, "R9 sys reset emc bits");

    // R9 vector reset as warm clear
    bus_write(4'h0, 32'hA05F_000B);
    bus_write(4'hC, 32'hFFFF_FFFF);
    idle(3);
    @(posedge clk); #1 vect_rst = 1'b1;
    @(posedge clk); #1 vect_rst = 1'b0;
    idle(5);
    bus_read(4'h0, 32'h0001_0009, "R9 vector reset keeps mask");
    bus_read(4'hC, 32'h0100_07F1, "R9 vector reset emc bits");
    check("R2 mask drives core", {31'd0, core_irq_mask}, 32'd1);

    // R6 exit by clearing enable
    bus_write(4'h0, 32'hA05F_0003);
    idle(5);
    bus_write(4'h0, 32'hA05F_0002);
    @(negedge clk); c0 = rcount; idle(10); @(negedge clk);
    check("R6 core runs after enable cleared", 32'(rcount > c0 + 5), 32'd1);
    bus_read(4'h0, 32'h0001_0002, "R6 status after exit");

    // R1 misaligned write ignored
    bus_write(4'hD, 32'h0000_0000);
    bus_read(4'hC, 32'h0100_07F1, "R1 misaligned ignored");

    // R8 power-on reset again
    @(posedge clk); #1 por_n = 1'b0;
    idle(2); #1 por_n = 1'b1;
    bus_read(4'h0, 32'h0001_0000, "R8 ctl after second power-on");
    bus_read(4'hC, 32'h0, "R8 emc after second power-on");
    bus_read(4'h8, 32'h0, "R8 data after second power-on");
    idle(2);
    finish_run();
  end
endmodule